// File: doc/BRIEF.md
# Program Memory Byte Access Unit

This unit gives a processor core byte-wide data access to a program memory that is organised as 16-bit words. A 21-bit byte pointer selects one byte anywhere in the program space. Its upper bits name the word and its lowest bit names the byte lane within that word. A single 8-bit latch sits between the core and memory. A read command fills the latch from the addressed lane. A write command copies the latch into the matching lane of a one-word holding register. The unit does not drive any flash programming sequence.

Every command carries a pointer step mode: keep, step up after the access, step down after the access, or step up before the access. A read takes two cycles. In the first cycle the command is accepted and the pointer is updated. In the second cycle the memory read port is driven and the latch loads at the end of that cycle. A write completes in the cycle in which it is accepted. The core can also load the pointer and the latch directly while the unit is idle.

Top module: `tbl_rd_unit`

## Requirements
- R1: After reset, the pointer, the latch, the holding word and the holding address are all zero, and busy and mem_rd_en are low.
- R2: When the unit is idle and no command is accepted, ptr_load loads ptr_wdata into the pointer on the next edge. ptr_load has no effect while busy is high.
- R3: A read command accepted while idle (cmd_valid=1, cmd_write=0) raises busy and mem_rd_en for exactly the next cycle, with mem_addr equal to the access address shifted right by one. At the end of that cycle the latch takes mem_rdata[7:0] when bit 0 of the access address is 0, and mem_rdata[15:8] when it is 1.
- R4: cmd_mode selects the step. 0 keeps the pointer. 1 accesses the old pointer and then adds 1. 2 accesses the old pointer and then subtracts 1. 3 adds 1 first and accesses the new value. The pointer shows its new value in the cycle after acceptance.
- R5: Pointer steps wrap modulo 2^21: 0x1FFFFF plus 1 gives 0, and 0 minus 1 gives 0x1FFFFF.
- R6: A write command accepted while idle (cmd_write=1) places the latch into the lane of the holding word selected by bit 0 of the access address and leaves the other lane unchanged. It sets the holding address to the access address shifted right by one and does not raise mem_rd_en.
- R7: When idle, latch_load loads latch_wdata into the latch. latch_load has no effect while busy is high.
- R8: A command presented while busy is high is ignored. The pointer and the holding word do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_load | input | 1 | Load pointer from ptr_wdata |
| ptr_wdata | input | 21 | Pointer load value |
| latch_load | input | 1 | Load latch from latch_wdata |
| latch_wdata | input | 8 | Latch load value |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write to holding register, 0 = read from memory |
| cmd_mode | input | 2 | Pointer step mode |
| busy | output | 1 | Read in progress; commands and loads are ignored |
| tbl_ptr | output | 21 | Current byte pointer |
| tbl_latch | output | 8 | Data latch |
| mem_rd_en | output | 1 | Program memory read strobe |
| mem_addr | output | 20 | Program memory word address |
| mem_rdata | input | 16 | Program memory word, valid in the mem_rd_en cycle |
| hold_word | output | 16 | Holding word for writes |
| hold_addr | output | 20 | Word address of the last write |

## Verification
A wrong lane select puts the other byte of the correct word into the latch one cycle after mem_rd_en. A pointer step that is wrong, or applied at the wrong time, shows up at tbl_ptr in the cycle after acceptance, before mem_rd_en rises. A busy flag that is stuck or too short lets stray loads land in the pointer, the latch or the holding word, and this is visible at the next edge. The bench checks every port one edge after each command, and again after each busy cycle in which stray stimulus is applied.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
  typedef enum logic [1:0] {
    TBL_KEEP     = 2'd0,
    TBL_POST_INC = 2'd1,
    TBL_POST_DEC = 2'd2,
    TBL_PRE_INC  = 2'd3
  } tbl_step_e;
endpackage

// File: rtl/tbl_ptr_unit.sv
module tbl_ptr_unit
  import tbl_pkg::*;
#(
  parameter int PW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [PW-1:0] load_val,
  input  logic          step_en,
  input  tbl_step_e     mode,
  output logic [PW-1:0] ptr,
  output logic [PW-1:0] acc_addr
);
  function automatic logic [PW-1:0] addr_of(input logic [PW-1:0] p, input tbl_step_e m);
    return (m == TBL_PRE_INC) ? p + PW'(1) : p;
  endfunction

  function automatic logic [PW-1:0] next_of(input logic [PW-1:0] p, input tbl_step_e m);
    case (m)
      TBL_POST_INC, TBL_PRE_INC: return p + PW'(1);
      TBL_POST_DEC:              return p - PW'(1);
      default:                   return p;
    endcase
  endfunction

  assign acc_addr = addr_of(ptr, mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (step_en) ptr <= next_of(ptr, mode);
    else if (load_en) ptr <= load_val;
  end

  p_wrap_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && (mode == TBL_POST_INC) && (ptr == '1) |=> ptr == '0);
  p_wrap_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && (mode == TBL_POST_DEC) && (ptr == '0) |=> ptr == '1);
  p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && (mode == TBL_KEEP) |=> $stable(ptr));
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en && !step_en |=> ptr == $past(load_val));
endmodule

// File: rtl/tbl_lane_pick.sv
module tbl_lane_pick #(
  parameter int BW    = 8,
  parameter int LANES = 2,
  localparam int SW   = $clog2(LANES)
) (
  input  logic [LANES*BW-1:0] word_in,
  input  logic [SW-1:0]       sel,
  output logic [BW-1:0]       byte_out
);
  function automatic logic [BW-1:0] pick(input logic [LANES*BW-1:0] w, input logic [SW-1:0] s);
    return w[s*BW +: BW];
  endfunction

  assign byte_out = pick(word_in, sel);
endmodule

// File: rtl/tbl_lane_merge.sv
module tbl_lane_merge #(
  parameter int BW    = 8,
  parameter int LANES = 2,
  localparam int SW   = $clog2(LANES)
) (
  input  logic [LANES*BW-1:0] word_in,
  input  logic [SW-1:0]       sel,
  input  logic [BW-1:0]       byte_in,
  output logic [LANES*BW-1:0] word_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word_out[g*BW +: BW] = (sel == SW'(g)) ? byte_in : word_in[g*BW +: BW];
  end
endmodule

// File: rtl/tbl_rd_unit.sv
module tbl_rd_unit
  import tbl_pkg::*;
#(
  parameter int PTR_W  = 21,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  localparam int SW    = $clog2(LANES),
  localparam int WA_W  = PTR_W - SW,
  localparam int WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load,
  input  logic [PTR_W-1:0]  ptr_wdata,
  input  logic              latch_load,
  input  logic [BYTE_W-1:0] latch_wdata,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [1:0]        cmd_mode,
  output logic              busy,
  output logic [PTR_W-1:0]  tbl_ptr,
  output logic [BYTE_W-1:0] tbl_latch,
  output logic              mem_rd_en,
  output logic [WA_W-1:0]   mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] hold_word,
  output logic [WA_W-1:0]   hold_addr
);
  logic              busy_q;
  logic              cmd_acc, rd_acc, wr_acc, ptr_ld_ok, latch_ld_ok;
  logic [PTR_W-1:0]  acc_addr;
  logic [WA_W-1:0]   rd_addr_q;
  logic [SW-1:0]     rd_sel_q;
  logic [BYTE_W-1:0] rd_byte;
  logic [WORD_W-1:0] merged;
  tbl_step_e         mode;

  assign mode        = tbl_step_e'(cmd_mode);
  assign cmd_acc     = cmd_valid && !busy_q;
  assign rd_acc      = cmd_acc && !cmd_write;
  assign wr_acc      = cmd_acc && cmd_write;
  assign ptr_ld_ok   = ptr_load && !busy_q && !cmd_acc;
  assign latch_ld_ok = latch_load && !busy_q;

  tbl_ptr_unit #(.PW(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_en(ptr_ld_ok), .load_val(ptr_wdata),
    .step_en(cmd_acc), .mode(mode), .ptr(tbl_ptr), .acc_addr(acc_addr)
  );

  tbl_lane_pick #(.BW(BYTE_W), .LANES(LANES)) u_pick (
    .word_in(mem_rdata), .sel(rd_sel_q), .byte_out(rd_byte)
  );

  tbl_lane_merge #(.BW(BYTE_W), .LANES(LANES)) u_merge (
    .word_in(hold_word), .sel(acc_addr[SW-1:0]), .byte_in(tbl_latch), .word_out(merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      rd_addr_q <= '0;
      rd_sel_q  <= '0;
    end else begin
      busy_q <= rd_acc;
      if (rd_acc) begin
        rd_addr_q <= acc_addr[PTR_W-1:SW];
        rd_sel_q  <= acc_addr[SW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tbl_latch <= '0;
    else if (busy_q)      tbl_latch <= rd_byte;
    else if (latch_ld_ok) tbl_latch <= latch_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_word <= '0;
      hold_addr <= '0;
    end else if (wr_acc) begin
      hold_word <= merged;
      hold_addr <= acc_addr[PTR_W-1:SW];
    end
  end

  assign busy      = busy_q;
  assign mem_rd_en = busy_q;
  assign mem_addr  = rd_addr_q;

  p_busy_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  p_rd_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && !cmd_write |=> mem_rd_en && (mem_addr == $past(acc_addr[PTR_W-1:SW])));
  p_wr_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd_write |=> !mem_rd_en);
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && !busy && cmd_write) |=> $stable(hold_word) && $stable(hold_addr));
  p_latch_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !latch_load |=> $stable(tbl_latch));
  p_busy_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tbl_ptr) && $stable(hold_word));
endmodule

// File: tb/tbl_rd_unit_test.sv
module tbl_rd_unit_test;
  localparam int K_PTR = 0, K_LATCH = 1, K_HOLDW = 2, K_HOLDA = 3, K_RDEN = 4, K_MADDR = 5, K_BUSY = 6;

  typedef struct {
    int          due;
    int          kind;
    logic [20:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_load = 1'b0, latch_load = 1'b0, cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [20:0] ptr_wdata = '0;
  logic [7:0]  latch_wdata = '0;
  logic [1:0]  cmd_mode = '0;
  logic        busy, mem_rd_en;
  logic [20:0] tbl_ptr;
  logic [7:0]  tbl_latch;
  logic [19:0] mem_addr, hold_addr;
  logic [15:0] mem_rdata, hold_word;

  item_t q[$];
  int    cyc = 0;
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;

  logic [20:0] m_ptr = '0;
  logic [7:0]  m_latch = '0;
  logic [15:0] m_hold = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] mem_model(input logic [19:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] + 8'h11};
  endfunction
  assign mem_rdata = mem_model(mem_addr);

  tbl_rd_unit uut (
    .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_wdata(ptr_wdata),
    .latch_load(latch_load), .latch_wdata(latch_wdata), .cmd_valid(cmd_valid),
    .cmd_write(cmd_write), .cmd_mode(cmd_mode), .busy(busy), .tbl_ptr(tbl_ptr),
    .tbl_latch(tbl_latch), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .hold_word(hold_word), .hold_addr(hold_addr)
  );

  function automatic logic [20:0] actual(input int k);
    case (k)
      K_PTR:   return tbl_ptr;
      K_LATCH: return 21'(tbl_latch);
      K_HOLDW: return 21'(hold_word);
      K_HOLDA: return 21'(hold_addr);
      K_RDEN:  return 21'(mem_rd_en);
      K_MADDR: return 21'(mem_addr);
      default: return 21'(busy);
    endcase
  endfunction

  task automatic check(input string req, input int k, input logic [20:0] exp);
    logic [20:0] act;
    act = actual(k);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s kind %0d: actual %h expected %h (cycle %0d)", req, k, act, exp, cyc);
    end
  endtask

  task automatic push(input int due, input int k, input logic [20:0] exp, input string req);
    item_t it;
    it.due = due; it.kind = k; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  // monitor: compares queued expectations once their cycle arrives
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--)
      if (q[i].due == cyc) begin
        check(q[i].req, q[i].kind, q[i].exp);
        q.delete(i);
      end
  end

  // independent model of the step rules (R4, R5)
  function automatic logic [20:0] access_of(input logic [20:0] p, input logic [1:0] m);
    logic [21:0] t;
    t = {1'b0, p} + ((m == 2'd3) ? 22'd1 : 22'd0);
    return t[20:0];
  endfunction

  function automatic logic [20:0] after_of(input logic [20:0] p, input logic [1:0] m);
    logic [21:0] t;
    if (m == 2'd0) t = {1'b0, p};
    else if (m == 2'd2) t = {1'b0, p} + 22'h3FFFFF;
    else t = {1'b0, p} + 22'd1;
    return t[20:0];
  endfunction

  task automatic load_ptr(input logic [20:0] v);
    @(negedge clk);
    ptr_load = 1'b1; ptr_wdata = v;
    m_ptr = v;
    push(cyc + 1, K_PTR, v, "R2");
    @(negedge clk);
    ptr_load = 1'b0;
  endtask

  task automatic load_latch(input logic [7:0] v);
    @(negedge clk);
    latch_load = 1'b1; latch_wdata = v;
    m_latch = v;
    push(cyc + 1, K_LATCH, 21'(v), "R7");
    @(negedge clk);
    latch_load = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] m, input bit disturb);
    logic [20:0] a;
    logic [15:0] w;
    @(negedge clk);
    a = access_of(m_ptr, m);
    m_ptr = after_of(m_ptr, m);
    w = mem_model(a[20:1]);
    m_latch = a[0] ? w[15:8] : w[7:0];
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_mode = m;
    push(cyc + 1, K_RDEN, 21'd1, "R3");
    push(cyc + 1, K_BUSY, 21'd1, "R3");
    push(cyc + 1, K_MADDR, 21'(a[20:1]), "R3");
    push(cyc + 1, K_PTR, m_ptr, (a == 21'h1FFFFF || m_ptr == 21'h1FFFFF) ? "R5" : "R4");
    push(cyc + 2, K_LATCH, 21'(m_latch), "R3");
    push(cyc + 2, K_BUSY, 21'd0, "R3");
    @(negedge clk);
    if (disturb) begin
      // stray stimulus during the busy cycle must be ignored (R2, R7, R8)
      cmd_valid = 1'b1; cmd_write = 1'b1; cmd_mode = 2'd1;
      ptr_load = 1'b1; ptr_wdata = 21'h0ABCD;
      latch_load = 1'b1; latch_wdata = ~m_latch;
      push(cyc + 1, K_PTR, m_ptr, "R8");
      push(cyc + 1, K_HOLDW, 21'(m_hold), "R8");
    end else cmd_valid = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0; ptr_load = 1'b0; latch_load = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] m);
    logic [20:0] a;
    @(negedge clk);
    a = access_of(m_ptr, m);
    m_ptr = after_of(m_ptr, m);
    if (a[0]) m_hold[15:8] = m_latch; else m_hold[7:0] = m_latch;
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_mode = m;
    push(cyc + 1, K_HOLDW, 21'(m_hold), "R6");
    push(cyc + 1, K_HOLDA, 21'(a[20:1]), "R6");
    push(cyc + 1, K_RDEN, 21'd0, "R6");
    push(cyc + 1, K_PTR, m_ptr, "R4");
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", K_PTR, 21'd0);
    check("R1", K_LATCH, 21'd0);
    check("R1", K_HOLDW, 21'd0);
    check("R1", K_HOLDA, 21'd0);
    check("R1", K_BUSY, 21'd0);
    check("R1", K_RDEN, 21'd0);

    load_ptr(21'h000100);
    do_read(2'd0, 1'b0);
    do_read(2'd1, 1'b1);
    do_read(2'd1, 1'b0);
    do_read(2'd2, 1'b1);
    do_read(2'd3, 1'b0);
    do_read(2'd3, 1'b1);
    load_ptr(21'h1FFFFF);
    do_read(2'd1, 1'b0);
    do_read(2'd2, 1'b0);
    do_read(2'd2, 1'b1);
    load_latch(8'hC3);
    do_write(2'd0);
    do_write(2'd2);
    load_latch(8'h5E);
    do_write(2'd3);
    load_ptr(21'h012345);
    load_latch(8'h77);
    do_write(2'd1);
    do_read(2'd0, 1'b1);
    do_write(2'd1);
    do_read(2'd3, 1'b0);

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    summary();
  end
endmodule